// File: doc/BRIEF.md
# Stream-to-Memory Ring Buffer Writer

This block takes words from a valid/ready stream and stores them, one after another, in a circular region of external memory. It acts as the write-side manager of an AXI4 port. Each accepted stream word becomes a separate write burst. The block issues the address first, then the data beats, then waits for the write response.

Configuration arrives on plain input pins, which a register file would drive: region base, region limit (exclusive), the consumer's read position, and an enable. The block publishes its committed write position. It keeps a completion flag and an error flag, and raises an interrupt while the completion flag is set and the interrupt is enabled.

The write position moves only once memory has acknowledged the burst. Software therefore never reads a slot that has not been written. When the next position would land on the consumer's read position, the stream is held off.

Top module: `ring_dma`

## Requirements
- R1: After reset, `m_awvalid`, `m_wvalid`, `m_bready`, `s_ready`, `done_status`, `err_status` and `irq` are low, and `wr_ptr` is zero.
- R2: Every address request carries `m_awaddr` equal to `wr_ptr`. `m_awlen` equals BURST_BEATS-1 (0 by default), `m_awsize` equals log2 of the bytes per word (3 for 64-bit words), and `m_awburst` is 2'b01 (incrementing). `m_wstrb` is all ones on every data beat.
- R3: Each burst has three phases in order: address handshake, then data beats with `m_wlast` on the final beat, then `m_bready` high until the response handshake. No new address request starts before the response of the previous burst.
- R4: During the data phase, `m_wvalid` follows `s_valid`, `m_wdata` is `s_data`, and `s_ready` equals `m_wready`. Outside the data phase, `s_ready` is low.
- R5: `wr_ptr` advances by one burst (BURST_BEATS x word bytes) on the response handshake only.
- R6: When the advanced position would reach or pass `cfg_end`, `wr_ptr` goes to `cfg_start` instead.
- R7: While the advanced position equals `cfg_rd_ptr`, no new burst starts, and `s_ready` stays low.
- R8: While `cfg_enable` is low, no new burst starts. A 0-to-1 change of `cfg_enable` loads `wr_ptr` from `cfg_start`.
- R9: `done_status` is set on every response handshake and cleared by a `done_clr` pulse; a set in the same cycle wins over the clear. `irq` is high exactly while `done_status` and `irq_enable` are both high.
- R10: A response with `m_bresp` other than 2'b00 sets `err_status` and still advances `wr_ptr`. `err_clr` clears `err_status`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Engine enable |
| cfg_start | input | ADDR_W | Ring base address |
| cfg_end | input | ADDR_W | Ring limit address, exclusive |
| cfg_rd_ptr | input | ADDR_W | Consumer read position |
| irq_enable | input | 1 | Interrupt mask, high to enable |
| done_clr | input | 1 | Clear pulse for the completion flag |
| err_clr | input | 1 | Clear pulse for the error flag |
| wr_ptr | output | ADDR_W | Committed write position |
| done_status | output | 1 | Completion flag |
| err_status | output | 1 | Error-response flag |
| irq | output | 1 | Interrupt request |
| s_valid | input | 1 | Stream word valid |
| s_ready | output | 1 | Stream word accepted |
| s_data | input | DATA_W | Stream word |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_awaddr | output | ADDR_W | Write address |
| m_awlen | output | 8 | Burst length minus one |
| m_awsize | output | 3 | Beat size code |
| m_awburst | output | 2 | Burst type |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Byte strobes |
| m_wlast | output | 1 | Final beat of burst |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| m_bresp | input | 2 | Write response code |

## Verification
A response handshake sets the completion flag, and a software clear pulse lowers it; the two can fall on the same clock edge. The bench raises `done_clr` on the same cycle it presents `m_bvalid`. It then requires `done_status` to remain set, and requires a later lone clear to drop both the flag and `irq`. A second collision is between the full check and the ring wrap. The bench drives the write position to the wrapped base, places the read position one slot beyond it, and requires that no address request appears until the read position moves.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2,
    ST_RESP = 2'd3
  } dma_state_e;

  localparam logic [1:0] BURST_INCR = 2'b01;
  localparam logic [1:0] RESP_OKAY  = 2'b00;
endpackage

// File: rtl/ring_dma_ptr.sv
module ring_dma_ptr #(
  parameter int ADDR_W = 32,
  parameter int STEP   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [ADDR_W-1:0] end_addr,
  input  logic [ADDR_W-1:0] rd_ptr,
  input  logic              commit,
  output logic [ADDR_W-1:0] wr_ptr,
  output logic              full,
  output logic              run_ok
);
  localparam logic [ADDR_W:0] STEP_EXT = (ADDR_W+1)'(STEP);

  logic              en_q;
  logic              reload;
  logic [ADDR_W:0]   sum_ext;
  logic [ADDR_W-1:0] adv_ptr;
  logic [ADDR_W-1:0] ptr_d;
  logic              ptr_en;

  always_comb begin
    sum_ext = {1'b0, wr_ptr} + STEP_EXT;
    if (sum_ext >= {1'b0, end_addr}) adv_ptr = start_addr;
    else                             adv_ptr = sum_ext[ADDR_W-1:0];
  end

  always_comb begin
    reload = enable && !en_q;
    ptr_en = reload || commit;
    ptr_d  = reload ? start_addr : adv_ptr;
  end

  assign full   = (adv_ptr == rd_ptr);
  assign run_ok = enable && en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      wr_ptr <= '0;
    end else begin
      en_q <= enable;
      if (ptr_en) wr_ptr <= ptr_d;
    end
  end
endmodule

// File: rtl/ring_dma_fsm.sv
module ring_dma_fsm
  import ring_dma_pkg::*;
#(
  parameter int DATA_W      = 64,
  parameter int ADDR_W      = 32,
  parameter int BURST_BEATS = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                go,
  input  logic [ADDR_W-1:0]   wr_ptr,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [DATA_W-1:0]   s_data,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [7:0]          m_awlen,
  output logic [2:0]          m_awsize,
  output logic [1:0]          m_awburst,
  output logic                m_wvalid,
  input  logic                m_wready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wlast,
  input  logic                m_bvalid,
  output logic                m_bready,
  input  logic [1:0]          m_bresp,
  output logic                commit,
  output logic                commit_err
);
  localparam int BYTES = DATA_W / 8;
  localparam int SIZE  = $clog2(BYTES);
  localparam int CNT_W = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;
  localparam logic [CNT_W-1:0] LAST_BEAT = CNT_W'(BURST_BEATS - 1);

  dma_state_e       state_q, state_d;
  logic [CNT_W-1:0] beat_q, beat_d;
  logic             beat_en;
  logic             w_fire;

  assign w_fire = (state_q == ST_DATA) && s_valid && m_wready;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (go && s_valid)              state_d = ST_ADDR;
      ST_ADDR: if (m_awready)                  state_d = ST_DATA;
      ST_DATA: if (w_fire && beat_q == LAST_BEAT) state_d = ST_RESP;
      ST_RESP: if (m_bvalid)                   state_d = ST_IDLE;
      default:                                 state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    beat_en = 1'b0;
    beat_d  = beat_q;
    if (state_q == ST_ADDR) begin
      beat_en = 1'b1;
      beat_d  = '0;
    end else if (w_fire) begin
      beat_en = 1'b1;
      beat_d  = beat_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      if (beat_en) beat_q <= beat_d;
    end
  end

  always_comb begin
    m_awvalid  = (state_q == ST_ADDR);
    m_awaddr   = wr_ptr;
    m_awlen    = 8'(BURST_BEATS - 1);
    m_awsize   = 3'(SIZE);
    m_awburst  = BURST_INCR;
    m_wvalid   = (state_q == ST_DATA) && s_valid;
    m_wdata    = s_data;
    m_wstrb    = '1;
    m_wlast    = (state_q == ST_DATA) && (beat_q == LAST_BEAT);
    s_ready    = (state_q == ST_DATA) && m_wready;
    m_bready   = (state_q == ST_RESP);
    commit     = (state_q == ST_RESP) && m_bvalid;
    commit_err = commit && (m_bresp != RESP_OKAY);
  end
endmodule

// File: rtl/ring_dma_irq.sv
module ring_dma_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic commit,
  input  logic commit_err,
  input  logic done_clr,
  input  logic err_clr,
  input  logic irq_enable,
  output logic done_status,
  output logic err_status,
  output logic irq
);
  logic done_d, err_d;

  always_comb begin
    done_d = done_status;
    if (commit)        done_d = 1'b1;
    else if (done_clr) done_d = 1'b0;
    err_d = err_status;
    if (commit_err)    err_d = 1'b1;
    else if (err_clr)  err_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_status <= 1'b0;
      err_status  <= 1'b0;
    end else begin
      done_status <= done_d;
      err_status  <= err_d;
    end
  end

  assign irq = done_status && irq_enable;
endmodule

// File: rtl/ring_dma.sv
module ring_dma #(
  parameter int DATA_W      = 64,
  parameter int ADDR_W      = 32,
  parameter int BURST_BEATS = 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_enable,
  input  logic [ADDR_W-1:0]   cfg_start,
  input  logic [ADDR_W-1:0]   cfg_end,
  input  logic [ADDR_W-1:0]   cfg_rd_ptr,
  input  logic                irq_enable,
  input  logic                done_clr,
  input  logic                err_clr,
  output logic [ADDR_W-1:0]   wr_ptr,
  output logic                done_status,
  output logic                err_status,
  output logic                irq,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [DATA_W-1:0]   s_data,
  output logic                m_awvalid,
  input  logic                m_awready,
  output logic [ADDR_W-1:0]   m_awaddr,
  output logic [7:0]          m_awlen,
  output logic [2:0]          m_awsize,
  output logic [1:0]          m_awburst,
  output logic                m_wvalid,
  input  logic                m_wready,
  output logic [DATA_W-1:0]   m_wdata,
  output logic [DATA_W/8-1:0] m_wstrb,
  output logic                m_wlast,
  input  logic                m_bvalid,
  output logic                m_bready,
  input  logic [1:0]          m_bresp
);
  localparam int STEP = BURST_BEATS * (DATA_W / 8);

  logic full, run_ok, commit, commit_err;

  ring_dma_ptr #(.ADDR_W(ADDR_W), .STEP(STEP)) u_ptr (
    .clk(clk), .rst_n(rst_n), .enable(cfg_enable),
    .start_addr(cfg_start), .end_addr(cfg_end), .rd_ptr(cfg_rd_ptr),
    .commit(commit), .wr_ptr(wr_ptr), .full(full), .run_ok(run_ok)
  );

  ring_dma_fsm #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .BURST_BEATS(BURST_BEATS)) u_fsm (
    .clk(clk), .rst_n(rst_n), .go(run_ok && !full), .wr_ptr(wr_ptr),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
    .m_awlen(m_awlen), .m_awsize(m_awsize), .m_awburst(m_awburst),
    .m_wvalid(m_wvalid), .m_wready(m_wready), .m_wdata(m_wdata),
    .m_wstrb(m_wstrb), .m_wlast(m_wlast),
    .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp),
    .commit(commit), .commit_err(commit_err)
  );

  ring_dma_irq u_irq (
    .clk(clk), .rst_n(rst_n), .commit(commit), .commit_err(commit_err),
    .done_clr(done_clr), .err_clr(err_clr), .irq_enable(irq_enable),
    .done_status(done_status), .err_status(err_status), .irq(irq)
  );
endmodule

// File: rtl/ring_dma_chk.sv
module ring_dma_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_enable,
  input logic [ADDR_W-1:0] wr_ptr,
  input logic              done_status,
  input logic              err_status,
  input logic              s_valid,
  input logic              s_ready,
  input logic              m_awvalid,
  input logic              m_awready,
  input logic [ADDR_W-1:0] m_awaddr,
  input logic              m_wvalid,
  input logic              m_wready,
  input logic              m_bvalid,
  input logic              m_bready,
  input logic [1:0]        m_bresp
);
  // R3: address request holds until accepted
  a_r3_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr)));

  // R3: at most one channel phase active
  a_r3_one_phase: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({m_awvalid, m_wvalid, m_bready}));

  // R4: an accepted stream word is a data handshake
  a_r4_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |-> (m_wvalid && m_wready));

  // R5: position moves only on response or enable reload
  a_r5_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!(m_bvalid && m_bready) && !(cfg_enable && !$past(cfg_enable)))
      |=> $stable(wr_ptr));

  // R9: every response sets completion flag
  a_r9_done_set: assert property (@(posedge clk) disable iff (!rst_n)
    (m_bvalid && m_bready) |=> done_status);

  // R10: error response sets error flag
  a_r10_err_set: assert property (@(posedge clk) disable iff (!rst_n)
    (m_bvalid && m_bready && m_bresp != 2'b00) |=> err_status);
endmodule

bind ring_dma ring_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable), .wr_ptr(wr_ptr),
  .done_status(done_status), .err_status(err_status),
  .s_valid(s_valid), .s_ready(s_ready),
  .m_awvalid(m_awvalid), .m_awready(m_awready), .m_awaddr(m_awaddr),
  .m_wvalid(m_wvalid), .m_wready(m_wready),
  .m_bvalid(m_bvalid), .m_bready(m_bready), .m_bresp(m_bresp)
);

// File: tb/ring_dma_bench.sv
`timescale 1ns/1ps
module ring_dma_bench;
  localparam int DATA_W = 64;
  localparam int ADDR_W = 32;
  localparam logic [31:0] START = 32'h1000;
  localparam logic [31:0] LIMIT = 32'h1040;
  localparam int NVEC = 6;
  // {response code, stream word}
  localparam logic [65:0] VEC [NVEC] = '{
    {2'b00, 64'h0123_4567_89AB_CDEF},
    {2'b00, 64'hFFFF_0000_FFFF_0000},
    {2'b10, 64'h0000_0000_0000_0001},
    {2'b00, 64'hDEAD_BEEF_CAFE_F00D},
    {2'b11, 64'h8000_0000_0000_0000},
    {2'b00, 64'h5A5A_A5A5_5A5A_A5A5}
  };

  logic clk, rst_n;
  logic cfg_enable, irq_enable, done_clr, err_clr;
  logic [ADDR_W-1:0] cfg_start, cfg_end, cfg_rd_ptr, wr_ptr;
  logic done_status, err_status, irq;
  logic s_valid, s_ready;
  logic [DATA_W-1:0] s_data;
  logic m_awvalid, m_awready, m_wvalid, m_wready, m_wlast, m_bvalid, m_bready;
  logic [ADDR_W-1:0] m_awaddr;
  logic [7:0] m_awlen;
  logic [2:0] m_awsize;
  logic [1:0] m_awburst, m_bresp;
  logic [DATA_W-1:0] m_wdata;
  logic [DATA_W/8-1:0] m_wstrb;

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_ptr;

  ring_dma u_ring_dma (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic burst(input logic [63:0] data, input logic [1:0] resp, input bit collide);
    int n;
    @(negedge clk);
    s_valid = 1'b1; s_data = data;
    n = 0;
    while (!m_awvalid && n < 50) begin @(negedge clk); n++; end
    chk(m_awvalid == 1'b1, "R3 address request", 64'(m_awvalid), 64'd1);
    chk(m_awaddr == exp_ptr, "R2 awaddr", 64'(m_awaddr), 64'(exp_ptr));
    chk(m_awlen == 8'd0 && m_awsize == 3'd3 && m_awburst == 2'b01, "R2 burst fields",
        64'({m_awlen, m_awsize, m_awburst}), 64'({8'd0, 3'd3, 2'b01}));
    chk(s_ready == 1'b0 && m_wvalid == 1'b0, "R4 no take in address phase",
        64'({s_ready, m_wvalid}), 64'd0);
    m_awready = 1'b1;
    @(negedge clk);
    m_awready = 1'b0;
    chk(m_awvalid == 1'b0 && m_wvalid == 1'b1, "R3 data phase", 64'({m_awvalid, m_wvalid}), 64'd1);
    chk(m_wdata == data, "R4 wdata", m_wdata, data);
    chk(m_wstrb == 8'hFF && m_wlast == 1'b1, "R2 R3 strobe and last", 64'({m_wstrb, m_wlast}), 64'h1FF);
    chk(s_ready == 1'b0, "R4 ready follows wready low", 64'(s_ready), 64'd0);
    m_wready = 1'b1;
    #1;
    chk(s_ready == 1'b1, "R4 ready follows wready high", 64'(s_ready), 64'd1);
    @(negedge clk);
    m_wready = 1'b0; s_valid = 1'b0;
    chk(m_bready == 1'b1 && m_wvalid == 1'b0, "R3 response phase", 64'({m_bready, m_wvalid}), 64'h2);
    chk(wr_ptr == exp_ptr, "R5 no advance before response", 64'(wr_ptr), 64'(exp_ptr));
    m_bvalid = 1'b1; m_bresp = resp;
    if (collide) done_clr = 1'b1;
    @(negedge clk);
    m_bvalid = 1'b0; done_clr = 1'b0;
    exp_ptr = (exp_ptr + 32'd8 >= LIMIT) ? START : exp_ptr + 32'd8;
    chk(wr_ptr == exp_ptr, "R5 R6 advance", 64'(wr_ptr), 64'(exp_ptr));
    chk(done_status == 1'b1, "R9 done set", 64'(done_status), 64'd1);
    chk(err_status == (resp != 2'b00), "R10 error flag", 64'(err_status), 64'(resp != 2'b00));
    chk(irq == irq_enable, "R9 irq", 64'(irq), 64'(irq_enable));
    if (!collide) begin
      done_clr = 1'b1; err_clr = 1'b1;
      @(negedge clk);
      done_clr = 1'b0; err_clr = 1'b0;
      chk({done_status, err_status, irq} == 3'b000, "R9 R10 clear", 64'({done_status, err_status, irq}), 64'd0);
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    summary();
  end

  initial begin
    rst_n = 1'b0; cfg_enable = 1'b0; irq_enable = 1'b1; done_clr = 1'b0; err_clr = 1'b0;
    cfg_start = START; cfg_end = LIMIT; cfg_rd_ptr = START;
    s_valid = 1'b0; s_data = '0;
    m_awready = 1'b0; m_wready = 1'b0; m_bvalid = 1'b0; m_bresp = 2'b00;
    exp_ptr = START;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk({m_awvalid, m_wvalid, m_bready, s_ready} == 4'b0, "R1 handshakes idle",
        64'({m_awvalid, m_wvalid, m_bready, s_ready}), 64'd0);
    chk({done_status, err_status, irq} == 3'b0, "R1 flags clear", 64'({done_status, err_status, irq}), 64'd0);
    chk(wr_ptr == '0, "R1 write position", 64'(wr_ptr), 64'd0);

    // R8 disabled: stream waits
    s_valid = 1'b1; s_data = VEC[0][63:0];
    repeat (5) @(negedge clk);
    chk(m_awvalid == 1'b0 && s_ready == 1'b0, "R8 disabled holds", 64'({m_awvalid, s_ready}), 64'd0);
    cfg_enable = 1'b1;
    @(negedge clk);
    chk(wr_ptr == START, "R8 reload on enable", 64'(wr_ptr), 64'(START));

    // table walk
    for (int i = 0; i < NVEC; i++) burst(VEC[i][63:0], VEC[i][65:64], 1'b0);

    // R6 wrap: positions 0x1030, 0x1038 then back to base
    cfg_rd_ptr = 32'h1018;
    burst(64'h1111, 2'b00, 1'b0);
    burst(64'h2222, 2'b00, 1'b0);
    chk(wr_ptr == START, "R6 wrap to base", 64'(wr_ptr), 64'(START));

    // R7 full: next slot equals read position
    cfg_rd_ptr = 32'h1008;
    s_valid = 1'b1;
    repeat (8) @(negedge clk);
    chk(m_awvalid == 1'b0 && s_ready == 1'b0, "R7 full blocks", 64'({m_awvalid, s_ready}), 64'd0);
    cfg_rd_ptr = 32'h1020;

    // R9 set and clear in same cycle: set wins
    burst(64'h3333, 2'b00, 1'b1);
    chk(done_status == 1'b1, "R9 set beats clear", 64'(done_status), 64'd1);
    done_clr = 1'b1;
    @(negedge clk);
    done_clr = 1'b0;
    chk(done_status == 1'b0 && irq == 1'b0, "R9 lone clear", 64'({done_status, irq}), 64'd0);

    // R9 masked interrupt
    irq_enable = 1'b0;
    burst(64'h4444, 2'b00, 1'b1);
    chk(irq == 1'b0 && done_status == 1'b1, "R9 masked irq", 64'({done_status, irq}), 64'h2);
    irq_enable = 1'b1;
    #1;
    chk(irq == 1'b1, "R9 unmask shows irq", 64'(irq), 64'd1);

    // R8 re-enable reloads base
    cfg_enable = 1'b0;
    @(negedge clk);
    cfg_enable = 1'b1;
    @(negedge clk);
    exp_ptr = START;
    chk(wr_ptr == START, "R8 reload again", 64'(wr_ptr), 64'(START));
    repeat (2) @(negedge clk);
    summary();
  end
endmodule